// File: doc/BRIEF.md
# Dual-Channel Framed PCM Serial Port

This block links a two-channel voice core to a framed serial PCM bus. The core gives it one 8-bit companded sample per channel per frame. The block shifts those samples out most significant bit first, timed by an external bit clock. In the other direction it collects incoming serial bits and hands each completed sample back to the core as a parallel byte with a one-cycle valid pulse. Transmit and receive each have their own frame sync input, which repeats at the 8 kHz frame rate. The bit clock may run at any of the usual voice-bus rates, from 64 kHz up to about 2 MHz.

A layout input chooses between two wirings. In split layout, each channel has its own transmit pin and its own receive pin, and both channels run with the same timing. In packed layout, one 16-bit frame carries channel 1 and then channel 2. That frame goes out on the first transmit pin and comes in on the second receive pin.

Each transmit pin has an enable output, so it can be built as an open-drain or tristate driver. An enable is high only while its own data slot is running. A power-down input drops both enables at once and clears the framing state. After reset, and again after power-down is released, the port waits a fixed settling time before it accepts any frame sync. The bit clock and the syncs are sampled with the fast system clock, so each bus edge is seen as a one-cycle strobe.

Top module: `pcmPort`

## Requirements
- R1: While reset is active and after it is released, both transmit enables and both receive valids are low and both receive sample outputs are 0.
- R2: A frame sync is sampled on the falling bit-clock edges. A frame starts only when the sync is seen high at one falling edge after it was seen low at the falling edge before. The result is the same for any sync width from 1 to 7 bit-clock periods.
- R3: In split layout, the first rising bit-clock edge after a frame start drives bit 7 (the MSB) of transmit sample 1 on transmit pin 1 and bit 7 of transmit sample 2 on transmit pin 2. Each later rising edge drives the next lower bit, for 8 bit periods in all.
- R4: In packed layout, transmit pin 1 carries 16 bits, MSB first: sample 1 bits 7..0 and then sample 2 bits 7..0. The enable of transmit pin 2 stays low.
- R5: A transmit enable is high only during the bit periods of its own slot (8 in split layout, 16 on pin 1 in packed layout). It is low in the bit period that holds the sync detection and from the first rising edge after the slot ends.
- R6: In split layout, each receive pin is sampled on the falling bit-clock edges that follow the frame start, MSB first. After the 8th bit, receive sample 1 (from receive pin 1) and receive sample 2 (from receive pin 2) each update with a valid pulse exactly one clock cycle long. A sample output changes only in a cycle where its valid is high.
- R7: In packed layout, 16 bits are taken from receive pin 2. The first 8 bits go to receive sample 1 with its valid, and the next 8 bits go to receive sample 2 with its valid. Receive pin 1 is ignored.
- R8: While power-down is high, both transmit enables are low in the same cycle. A frame that power-down interrupts produces no receive valid.
- R9: For WAKE_CYCLES clock cycles after reset release, or after power-down falls, frame syncs are ignored and both transmit enables stay low.
- R10: The transmit samples are latched at the first rising edge of the frame. Changing them later in the frame does not alter the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrDn | input | 1 | Power-down: turns off the drivers and clears the framing state |
| packedMode | input | 1 | 1 selects the packed 16-bit layout, 0 the split layout |
| bclk | input | 1 | Serial bit clock |
| fsTx | input | 1 | Transmit frame sync |
| fsRx | input | 1 | Receive frame sync |
| txSample1 | input | SAMPLE_W | Channel 1 sample to send |
| txSample2 | input | SAMPLE_W | Channel 2 sample to send |
| rxPin1 | input | 1 | Serial receive data, pin 1 |
| rxPin2 | input | 1 | Serial receive data, pin 2 |
| txPin1 | output | 1 | Serial transmit data, pin 1 |
| txOe1 | output | 1 | Driver enable for transmit pin 1 |
| txPin2 | output | 1 | Serial transmit data, pin 2 |
| txOe2 | output | 1 | Driver enable for transmit pin 2 |
| rxSample1 | output | SAMPLE_W | Received channel 1 sample |
| rxSample2 | output | SAMPLE_W | Received channel 2 sample |
| rxValid1 | output | 1 | One-cycle strobe: rxSample1 updated |
| rxValid2 | output | 1 | One-cycle strobe: rxSample2 updated |

## Verification
Both layouts are run with random sample bytes, random sync widths and random noise on the unused receive pin. The bench compares every bit period and the enable window against a bit-level model. Directed frames with one-hot and all-ones/all-zeros bytes show a reversed bit order, or the channel 1/channel 2 order, as a mismatch at a known bit. Sync widths of 1 and 7 periods show whether the start is taken from a level or from a transition. A power-down in the middle of a frame, and a frame sent during the settling window, check that nothing is driven and no valid appears.

// File: rtl/pcmPortPkg.sv
package pcmPortPkg;

  // Strobes and frame state passed from control to datapath
  typedef struct packed {
    logic txLoad;   // latch samples and drive first bit
    logic txShift;  // advance to next transmit bit
    logic txDrive;  // transmit slot running
    logic txPk;     // transmit frame uses packed layout
    logic rxShift;  // shift one received bit
    logic rxCap1;   // channel 1 byte complete
    logic rxCap2;   // channel 2 byte complete
    logic rxPk;     // receive frame uses packed layout
  } pcmStrobe_t;

endpackage

// File: rtl/pcmPortCtrl.sv
module pcmPortCtrl
  import pcmPortPkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int WAKE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDn,
  input  logic       packedMode,
  input  logic       bclk,
  input  logic       fsTx,
  input  logic       fsRx,
  output pcmStrobe_t strb
);

  localparam int FRAME_MAX = 2 * SAMPLE_W;
  localparam int CNT_W     = $clog2(FRAME_MAX);
  localparam int WAKE_W    = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_SPLIT  = CNT_W'(SAMPLE_W - 1);
  localparam logic [CNT_W-1:0] LAST_PACKED = CNT_W'(FRAME_MAX - 1);

  // bus sampling
  logic bclkQ1, bclkQ2, fsTxQ, fsRxQ;
  logic bclkRise, bclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ1 <= 1'b0;
      bclkQ2 <= 1'b0;
      fsTxQ  <= 1'b0;
      fsRxQ  <= 1'b0;
    end else begin
      bclkQ1 <= bclk;
      bclkQ2 <= bclkQ1;
      fsTxQ  <= fsTx;
      fsRxQ  <= fsRx;
    end
  end

  assign bclkRise = bclkQ1 & ~bclkQ2;
  assign bclkFall = ~bclkQ1 & bclkQ2;

  // settling timer
  logic [WAKE_W-1:0] wakeCnt;
  logic              ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           wakeCnt <= '0;
    else if (pwrDn)                      wakeCnt <= '0;
    else if (wakeCnt != WAKE_W'(WAKE_CYCLES)) wakeCnt <= wakeCnt + 1'b1;
  end

  assign ready = (wakeCnt == WAKE_W'(WAKE_CYCLES));

  // transmit framing
  logic             fsTxPrev, txPend, txActive, txPk;
  logic [CNT_W-1:0] txCnt, txLast;

  assign txLast = txPk ? LAST_PACKED : LAST_SPLIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsTxPrev <= 1'b0;
      txPend   <= 1'b0;
      txActive <= 1'b0;
      txPk     <= 1'b0;
      txCnt    <= '0;
    end else if (pwrDn) begin
      fsTxPrev <= 1'b0;
      txPend   <= 1'b0;
      txActive <= 1'b0;
      txCnt    <= '0;
    end else begin
      if (bclkFall) begin
        fsTxPrev <= fsTxQ;
        if (fsTxQ && !fsTxPrev && ready) txPend <= 1'b1;
      end
      if (bclkRise) begin
        if (txPend) begin
          txPend   <= 1'b0;
          txActive <= 1'b1;
          txCnt    <= '0;
          txPk     <= packedMode;
        end else if (txActive) begin
          if (txCnt == txLast) txActive <= 1'b0;
          else                 txCnt    <= txCnt + 1'b1;
        end
      end
    end
  end

  // receive framing
  logic             fsRxPrev, rxActive, rxPk;
  logic [CNT_W-1:0] rxCnt, rxLast;

  assign rxLast = rxPk ? LAST_PACKED : LAST_SPLIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsRxPrev <= 1'b0;
      rxActive <= 1'b0;
      rxPk     <= 1'b0;
      rxCnt    <= '0;
    end else if (pwrDn) begin
      fsRxPrev <= 1'b0;
      rxActive <= 1'b0;
      rxCnt    <= '0;
    end else if (bclkFall) begin
      fsRxPrev <= fsRxQ;
      if (rxActive) begin
        if (rxCnt == rxLast) rxActive <= 1'b0;
        else                 rxCnt    <= rxCnt + 1'b1;
      end
      if (fsRxQ && !fsRxPrev && ready) begin
        rxActive <= 1'b1;
        rxCnt    <= '0;
        rxPk     <= packedMode;
      end
    end
  end

  // strobes to datapath
  logic rxStep;
  assign rxStep = bclkFall & rxActive & ~pwrDn;

  always_comb begin
    strb         = '0;
    strb.txLoad  = bclkRise & txPend & ~pwrDn;
    strb.txShift = bclkRise & txActive & ~txPend & (txCnt != txLast) & ~pwrDn;
    strb.txDrive = txActive;
    strb.txPk    = txPk;
    strb.rxShift = rxStep;
    strb.rxCap1  = rxStep & (rxCnt == LAST_SPLIT);
    strb.rxCap2  = rxStep & (rxCnt == rxLast);
    strb.rxPk    = rxPk;
  end

endmodule

// File: rtl/pcmPortDatapath.sv
module pcmPortDatapath
  import pcmPortPkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrDn,
  input  pcmStrobe_t          strb,
  input  logic [SAMPLE_W-1:0] txSample1,
  input  logic [SAMPLE_W-1:0] txSample2,
  input  logic                rxPin1,
  input  logic                rxPin2,
  output logic                txPin1,
  output logic                txOe1,
  output logic                txPin2,
  output logic                txOe2,
  output logic [SAMPLE_W-1:0] rxSample1,
  output logic [SAMPLE_W-1:0] rxSample2,
  output logic                rxValid1,
  output logic                rxValid2
);

  localparam int FW    = 2 * SAMPLE_W;
  localparam int N_CH  = 2;

  // transmit shifters: pin 1 holds both bytes for packed layout
  logic [FW-1:0]       txSh1;
  logic [SAMPLE_W-1:0] txSh2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh1 <= '0;
      txSh2 <= '0;
    end else if (strb.txLoad) begin
      txSh1 <= {txSample1, txSample2};
      txSh2 <= txSample2;
    end else if (strb.txShift) begin
      txSh1 <= {txSh1[FW-2:0], 1'b0};
      txSh2 <= {txSh2[SAMPLE_W-2:0], 1'b0};
    end
  end

  assign txPin1 = txSh1[FW-1];
  assign txPin2 = txSh2[SAMPLE_W-1];
  assign txOe1  = strb.txDrive & ~pwrDn;
  assign txOe2  = strb.txDrive & ~strb.txPk & ~pwrDn;

  // receive pins, aligned with bus sampling in control
  logic rxPinQ1, rxPinQ2;
  logic [SAMPLE_W-2:0] rxSh1, rxSh2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPinQ1 <= 1'b0;
      rxPinQ2 <= 1'b0;
      rxSh1   <= '0;
      rxSh2   <= '0;
    end else begin
      rxPinQ1 <= rxPin1;
      rxPinQ2 <= rxPin2;
      if (strb.rxShift) begin
        rxSh1 <= {rxSh1[SAMPLE_W-3:0], rxPinQ1};
        rxSh2 <= {rxSh2[SAMPLE_W-3:0], rxPinQ2};
      end
    end
  end

  logic [SAMPLE_W-1:0] chNext [N_CH];
  logic                chCap  [N_CH];
  logic [SAMPLE_W-1:0] chData [N_CH];
  logic                chVal  [N_CH];

  always_comb begin
    chNext[0] = strb.rxPk ? {rxSh2, rxPinQ2} : {rxSh1, rxPinQ1};
    chNext[1] = {rxSh2, rxPinQ2};
    chCap[0]  = strb.rxCap1;
    chCap[1]  = strb.rxCap2;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_rxCh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chData[ch] <= '0;
        chVal[ch]  <= 1'b0;
      end else begin
        chVal[ch] <= chCap[ch];
        if (chCap[ch]) chData[ch] <= chNext[ch];
      end
    end
  end

  assign rxSample1 = chData[0];
  assign rxSample2 = chData[1];
  assign rxValid1  = chVal[0];
  assign rxValid2  = chVal[1];

endmodule

// File: rtl/pcmPort.sv
module pcmPort
  import pcmPortPkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int WAKE_CYCLES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrDn,
  input  logic                packedMode,
  input  logic                bclk,
  input  logic                fsTx,
  input  logic                fsRx,
  input  logic [SAMPLE_W-1:0] txSample1,
  input  logic [SAMPLE_W-1:0] txSample2,
  input  logic                rxPin1,
  input  logic                rxPin2,
  output logic                txPin1,
  output logic                txOe1,
  output logic                txPin2,
  output logic                txOe2,
  output logic [SAMPLE_W-1:0] rxSample1,
  output logic [SAMPLE_W-1:0] rxSample2,
  output logic                rxValid1,
  output logic                rxValid2
);

  pcmStrobe_t strb;

  pcmPortCtrl #(.SAMPLE_W(SAMPLE_W), .WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .packedMode(packedMode),
    .bclk(bclk), .fsTx(fsTx), .fsRx(fsRx), .strb(strb)
  );

  pcmPortDatapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .strb(strb),
    .txSample1(txSample1), .txSample2(txSample2),
    .rxPin1(rxPin1), .rxPin2(rxPin2),
    .txPin1(txPin1), .txOe1(txOe1), .txPin2(txPin2), .txOe2(txOe2),
    .rxSample1(rxSample1), .rxSample2(rxSample2),
    .rxValid1(rxValid1), .rxValid2(rxValid2)
  );

endmodule

// File: rtl/pcmPortChk.sv
module pcmPortChk #(
  parameter int SAMPLE_W    = 8,
  parameter int WAKE_CYCLES = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                pwrDn,
  input logic                packedMode,
  input logic                txOe1,
  input logic                txOe2,
  input logic [SAMPLE_W-1:0] rxSample1,
  input logic [SAMPLE_W-1:0] rxSample2,
  input logic                rxValid1,
  input logic                rxValid2
);

  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic [WAKE_W-1:0] settleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  settleCnt <= '0;
    else if (pwrDn)                             settleCnt <= '0;
    else if (settleCnt != WAKE_W'(WAKE_CYCLES)) settleCnt <= settleCnt + 1'b1;
  end

  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    pwrDn |-> (!txOe1 && !txOe2)); // R8

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (settleCnt != WAKE_W'(WAKE_CYCLES)) |-> (!txOe1 && !txOe2)); // R9

  AST_VALID1_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid1 |=> !rxValid1); // R6

  AST_VALID2_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid2 |=> !rxValid2); // R6

  AST_SAMPLE1_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxSample1 != $past(rxSample1)) |-> rxValid1); // R6

  AST_SAMPLE2_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxSample2 != $past(rxSample2)) |-> rxValid2); // R6

  AST_PACKED_PIN2_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOe2) |-> !$past(packedMode)); // R4

endmodule

bind pcmPort pcmPortChk #(.SAMPLE_W(SAMPLE_W), .WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .packedMode(packedMode),
  .txOe1(txOe1), .txOe2(txOe2),
  .rxSample1(rxSample1), .rxSample2(rxSample2),
  .rxValid1(rxValid1), .rxValid2(rxValid2)
);

// File: tb/pcmPort_tb.sv
module pcmPort_tb;

  localparam int W    = 8;
  localparam int WAKE = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrDn = 1'b0, packedMode = 1'b0, bclk = 1'b0, fsTx = 1'b0, fsRx = 1'b0;
  logic [W-1:0] txSample1 = '0, txSample2 = '0;
  logic rxPin1 = 1'b0, rxPin2 = 1'b0;
  logic txPin1, txOe1, txPin2, txOe2, rxValid1, rxValid2;
  logic [W-1:0] rxSample1, rxSample2;

  int checks = 0;
  int errors = 0;
  int v1Cnt = 0, v2Cnt = 0;
  logic [W-1:0] v1Last = '0, v2Last = '0;

  always #2 clk = ~clk;

  pcmPort #(.SAMPLE_W(W), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .packedMode(packedMode),
    .bclk(bclk), .fsTx(fsTx), .fsRx(fsRx),
    .txSample1(txSample1), .txSample2(txSample2),
    .rxPin1(rxPin1), .rxPin2(rxPin2),
    .txPin1(txPin1), .txOe1(txOe1), .txPin2(txPin2), .txOe2(txOe2),
    .rxSample1(rxSample1), .rxSample2(rxSample2),
    .rxValid1(rxValid1), .rxValid2(rxValid2)
  );

  always @(negedge clk) begin
    if (rxValid1) begin v1Cnt++; v1Last = rxSample1; end
    if (rxValid2) begin v2Cnt++; v2Last = rxSample2; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected transmit bit for bit period p (1-based inside slot)
  function automatic logic expPin1(input bit pk, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input int p);
    logic [2*W-1:0] word;
    word = pk ? {a, b} : {a, b};
    return word[2*W - p];
  endfunction

  // one bit-clock period: drive at the rise, sample before the fall
  task automatic bitPeriod(input logic fsT, input logic fsR, input logic r1,
                           input logic r2, output logic o1, output logic e1,
                           output logic o2, output logic e2);
    @(negedge clk);
    bclk = 1'b1; fsTx = fsT; fsRx = fsR; rxPin1 = r1; rxPin2 = r2;
    repeat (7) @(negedge clk);
    o1 = txPin1; e1 = txOe1; o2 = txPin2; e2 = txOe2;
    @(negedge clk);
    bclk = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic idle(input int n);
    logic a, b, c, d;
    for (int i = 0; i < n; i++) bitPeriod(1'b0, 1'b0, 1'b0, 1'b0, a, b, c, d);
  endtask

  task automatic runFrame(input bit pk, input logic [W-1:0] t1, input logic [W-1:0] t2,
                          input logic [W-1:0] r1, input logic [W-1:0] r2,
                          input int fsLen, input bit live);
    int fb;
    int s1, s2;
    logic o1, e1, o2, e2, d1, d2;
    logic [2*W-1:0] rxWord;
    fb = pk ? 2*W : W;
    rxWord = {r1, r2};
    packedMode = pk;
    txSample1 = t1; txSample2 = t2;
    s1 = v1Cnt; s2 = v2Cnt;
    for (int p = 0; p <= fb + 1; p++) begin
      d1 = 1'($urandom);
      d2 = 1'($urandom);
      if (p >= 1 && p <= fb) begin
        if (pk) d2 = rxWord[2*W - p];
        else begin d1 = r1[W - p]; d2 = r2[W - p]; end
      end
      if (p == 3) begin txSample1 = 8'($urandom); txSample2 = ~t2; end // R10 late change
      bitPeriod(p < fsLen, p < fsLen, d1, d2, o1, e1, o2, e2);
      if (live && p >= 1 && p <= fb) begin
        check(e1 === 1'b1, "R5", "oe1 in slot", int'(e1), 1);
        check(o1 === expPin1(pk, t1, t2, p), pk ? "R4" : "R3", "pin1 bit",
              int'(o1), int'(expPin1(pk, t1, t2, p)));
        if (p == 4) check(o1 === expPin1(pk, t1, t2, p), "R10", "latched bit", int'(o1),
                          int'(expPin1(pk, t1, t2, p)));
        if (pk) check(e2 === 1'b0, "R4", "oe2 packed", int'(e2), 0);
        else begin
          check(e2 === 1'b1, "R5", "oe2 in slot", int'(e2), 1);
          check(o2 === t2[W - p], "R3", "pin2 bit", int'(o2), int'(t2[W - p]));
        end
      end else begin
        check(e1 === 1'b0 && e2 === 1'b0, live ? "R5" : "R9", "oe outside slot",
              int'({e1, e2}), 0);
      end
    end
    idle(1);
    if (live) begin
      check(v1Cnt == s1 + 1, pk ? "R7" : "R6", "valid1 count", v1Cnt - s1, 1);
      check(v2Cnt == s2 + 1, pk ? "R7" : "R6", "valid2 count", v2Cnt - s2, 1);
      check(v1Last === r1, pk ? "R7" : "R6", "rx sample1", int'(v1Last), int'(r1));
      check(v2Last === r2, pk ? "R7" : "R6", "rx sample2", int'(v2Last), int'(r2));
    end else begin
      check(v1Cnt == s1 && v2Cnt == s2, "R9", "no valid while settling",
            v1Cnt - s1 + v2Cnt - s2, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic o1, e1, o2, e2;
    int s1, s2;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    check(txOe1 === 1'b0 && txOe2 === 1'b0, "R1", "oe in reset", int'({txOe1, txOe2}), 0);
    check(rxValid1 === 1'b0 && rxValid2 === 1'b0, "R1", "valid in reset",
          int'({rxValid1, rxValid2}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rxSample1 === 8'h00 && rxSample2 === 8'h00, "R1", "samples after reset",
          int'({rxSample1, rxSample2}), 0);
    // R9: sync inside the settling window is ignored
    runFrame(1'b0, 8'hA5, 8'h3C, 8'h11, 8'h22, 2, 1'b0);
    idle(3);

    // directed: R2 sync widths, R3 bit order, R4 channel order
    runFrame(1'b0, 8'h80, 8'h01, 8'h80, 8'h01, 1, 1'b1);
    runFrame(1'b0, 8'hFF, 8'h00, 8'h00, 8'hFF, 7, 1'b1);
    runFrame(1'b1, 8'h01, 8'h80, 8'hF0, 8'h0F, 1, 1'b1);
    runFrame(1'b1, 8'h00, 8'hFF, 8'hC3, 8'h5A, 7, 1'b1);
    check(1'b1, "R2", "width 1 and 7 frames done", 0, 0);

    // random frames in both layouts
    for (int i = 0; i < 24; i++) begin
      runFrame(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
               1 + int'($urandom % 7), 1'b1);
    end

    // R8: power-down in mid-frame
    packedMode = 1'b0;
    s1 = v1Cnt; s2 = v2Cnt;
    bitPeriod(1'b1, 1'b1, 1'b1, 1'b0, o1, e1, o2, e2);
    bitPeriod(1'b1, 1'b1, 1'b1, 1'b0, o1, e1, o2, e2);
    bitPeriod(1'b0, 1'b0, 1'b0, 1'b1, o1, e1, o2, e2);
    check(e1 === 1'b1, "R8", "slot running before power-down", int'(e1), 1);
    @(negedge clk);
    pwrDn = 1'b1;
    #1;
    check(txOe1 === 1'b0 && txOe2 === 1'b0, "R8", "oe drop at once", int'({txOe1, txOe2}), 0);
    idle(10);
    check(v1Cnt == s1 && v2Cnt == s2, "R8", "no valid after interrupt",
          v1Cnt - s1 + v2Cnt - s2, 0);
    pwrDn = 1'b0;
    runFrame(1'b0, 8'h5A, 8'hA5, 8'h77, 8'h88, 2, 1'b0); // R9 after power-down
    idle(3);
    runFrame(1'b1, 8'h96, 8'h69, 8'h12, 8'h34, 3, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule